// File: doc/BRIEF.md
# Classic-to-Pipelined Bus Bridge

This bridge joins a bus master that uses the Wishbone classic single-transfer handshake to a slave that uses the Wishbone pipelined handshake. The classic master raises its cycle and strobe lines and holds them, with address, write data and write flag, until it sees an acknowledge. The pipelined slave expects one strobe per transfer. It may refuse that strobe with a stall signal, and it answers later with an acknowledge whose delay can vary.

The bridge registers the request fields when a classic request appears. From the next cycle it presents one strobe downstream and keeps that strobe up for as long as the slave stalls. It drops the strobe right after the slave takes it. It then keeps the downstream cycle open until the slave acknowledges. That acknowledge, with the slave's read data, goes straight back to the classic master in the same cycle. If the master abandons its cycle while a transfer is in flight, the bridge still waits for the slave's acknowledge and does not pass it upward. All transfers are single, aligned, full-width words, and there are no byte selects.

Top module: `wbc2p_bridge`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the bridge returns to idle: in the following cycle `pl_cyc_o`, `pl_stb_o` and `cm_ack_o` are all 0.
- R2: When the bridge is idle and `cm_cyc_i` and `cm_stb_i` are both 1 at a clock edge, then in the next cycle `pl_cyc_o` and `pl_stb_o` are 1, and `pl_adr_o`, `pl_we_o` and `pl_dat_o` equal the master's address, write flag and write data sampled at that edge.
- R3: While `pl_stb_o` is 1 and `pl_stall_i` is 1 at a clock edge, `pl_stb_o` stays 1 in the next cycle and `pl_adr_o`, `pl_we_o` and `pl_dat_o` keep their values.
- R4: Each classic request produces exactly one accepted strobe. After an edge where `pl_stb_o` is 1 and `pl_stall_i` is 0, `pl_stb_o` is 0 in the next cycle, even though the master still holds its request.
- R5: `pl_cyc_o` is 1 whenever `pl_stb_o` is 1, and stays 1 from the first strobe cycle until the edge at which the slave's acknowledge for the accepted transfer is sampled. It is 0 in the cycle after that edge.
- R6: In the cycle in which `pl_ack_i` is 1 for the outstanding transfer, and the master still holds `cm_cyc_i` and `cm_stb_i`, `cm_ack_o` is 1 in that same cycle and `cm_dat_o` equals `pl_dat_i`. `cm_ack_o` is 1 only in cycles where `pl_ack_i` is 1.
- R7: The acknowledge is returned correctly for any number of stall cycles and any acknowledge delay of one or more cycles after acceptance. `cm_ack_o` stays 0 until the slave acknowledges.
- R8: If `cm_cyc_i` falls after a request has started but before its acknowledge, `pl_cyc_o` stays 1 until the slave acknowledges. That acknowledge is not passed up: `cm_ack_o` stays 0.
- R9: A `pl_ack_i` pulse while no transfer is outstanding has no effect: `cm_ack_o` stays 0 and `pl_cyc_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cm_cyc_i | input | 1 | Classic master cycle |
| cm_stb_i | input | 1 | Classic master strobe |
| cm_we_i | input | 1 | Classic master write flag |
| cm_adr_i | input | ADDR_W | Classic master word address |
| cm_dat_i | input | DATA_W | Classic master write data |
| cm_dat_o | output | DATA_W | Read data returned to the classic master |
| cm_ack_o | output | 1 | One-cycle acknowledge to the classic master |
| pl_cyc_o | output | 1 | Pipelined cycle to the slave |
| pl_stb_o | output | 1 | Pipelined strobe to the slave |
| pl_we_o | output | 1 | Write flag to the slave |
| pl_adr_o | output | ADDR_W | Address to the slave |
| pl_dat_o | output | DATA_W | Write data to the slave |
| pl_dat_i | input | DATA_W | Read data from the slave |
| pl_stall_i | input | 1 | Slave stall |
| pl_ack_i | input | 1 | Slave acknowledge |

## Verification
The bound checker watches the cycle-level rules on every clock. It checks that the strobe holds with stable fields under stall and falls after acceptance. It checks that the strobe never appears without the cycle line, and that the cycle line stays open while a transfer waits and closes after the acknowledge. It also checks that the master acknowledge never appears without a slave acknowledge or outside a cycle. The directed scenarios are needed for the rest: that the fields carried downstream are the master's own values, that read data arrives intact, that long stalls and long acknowledge delays still complete, that an abandoned transfer swallows its acknowledge, and that a stray acknowledge while idle does nothing.

// File: rtl/c2p_pkg.sv
package c2p_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } c2p_state_e;

    typedef struct packed {
        c2p_state_e state;
        logic       dropped;
    } c2p_ctl_s;

endpackage

// File: rtl/c2p_seq.sv
// Request sequencer: idle -> request (strobe until not stalled) -> wait for ack.
module c2p_seq
    import c2p_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cm_cyc,
    input  logic       cm_stb,
    input  logic       pl_stall,
    input  logic       pl_ack,
    output c2p_state_e state,
    output logic       dropped,
    output logic       capture
);

    c2p_ctl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d   = ctl_q;
        capture = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (cm_cyc && cm_stb) begin
                    capture       = 1'b1;
                    ctl_d.state   = ST_REQ;
                    ctl_d.dropped = 1'b0;
                end
            end
            ST_REQ: begin
                if (!cm_cyc) begin
                    ctl_d.dropped = 1'b1;
                end
                if (!pl_stall) begin
                    ctl_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!cm_cyc) begin
                    ctl_d.dropped = 1'b1;
                end
                if (pl_ack) begin
                    ctl_d.state   = ST_IDLE;
                    ctl_d.dropped = 1'b0;
                end
            end
            default: begin
                ctl_d.state   = ST_IDLE;
                ctl_d.dropped = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.state   <= ST_IDLE;
            ctl_q.dropped <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign state   = ctl_q.state;
    assign dropped = ctl_q.dropped;

endmodule

// File: rtl/c2p_hold.sv
// Holds the request fields from the start of a request until the next one.
module c2p_hold #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              we_in,
    input  logic [ADDR_W-1:0] adr_in,
    input  logic [DATA_W-1:0] dat_in,
    output logic              we_out,
    output logic [ADDR_W-1:0] adr_out,
    output logic [DATA_W-1:0] dat_out
);

    logic              we_d,  we_q;
    logic [ADDR_W-1:0] adr_d, adr_q;
    logic [DATA_W-1:0] dat_d, dat_q;

    always_comb begin
        we_d  = we_q;
        adr_d = adr_q;
        dat_d = dat_q;
        if (capture) begin
            we_d  = we_in;
            adr_d = adr_in;
            dat_d = dat_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q  <= 1'b0;
            adr_q <= '0;
            dat_q <= '0;
        end else begin
            we_q  <= we_d;
            adr_q <= adr_d;
            dat_q <= dat_d;
        end
    end

    assign we_out  = we_q;
    assign adr_out = adr_q;
    assign dat_out = dat_q;

endmodule

// File: rtl/c2p_reply.sv
// Return path: forwards the slave acknowledge only for a live, waiting request.
module c2p_reply
    import c2p_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  c2p_state_e        state,
    input  logic              dropped,
    input  logic              cm_cyc,
    input  logic              cm_stb,
    input  logic              pl_ack,
    input  logic [DATA_W-1:0] pl_dat,
    output logic              cm_ack,
    output logic [DATA_W-1:0] cm_dat
);

    logic waiting;
    logic live;

    always_comb begin
        waiting = (state == ST_WAIT);
        live    = cm_cyc && cm_stb && !dropped;
        cm_ack  = pl_ack && waiting && live;
        cm_dat  = pl_dat;
    end

endmodule

// File: rtl/wbc2p_bridge.sv
module wbc2p_bridge
    import c2p_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cm_cyc_i,
    input  logic              cm_stb_i,
    input  logic              cm_we_i,
    input  logic [ADDR_W-1:0] cm_adr_i,
    input  logic [DATA_W-1:0] cm_dat_i,
    output logic [DATA_W-1:0] cm_dat_o,
    output logic              cm_ack_o,
    output logic              pl_cyc_o,
    output logic              pl_stb_o,
    output logic              pl_we_o,
    output logic [ADDR_W-1:0] pl_adr_o,
    output logic [DATA_W-1:0] pl_dat_o,
    input  logic [DATA_W-1:0] pl_dat_i,
    input  logic              pl_stall_i,
    input  logic              pl_ack_i
);

    c2p_state_e state;
    logic       dropped;
    logic       capture;

    c2p_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .cm_cyc   (cm_cyc_i),
        .cm_stb   (cm_stb_i),
        .pl_stall (pl_stall_i),
        .pl_ack   (pl_ack_i),
        .state    (state),
        .dropped  (dropped),
        .capture  (capture)
    );

    c2p_hold #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_hold (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .we_in   (cm_we_i),
        .adr_in  (cm_adr_i),
        .dat_in  (cm_dat_i),
        .we_out  (pl_we_o),
        .adr_out (pl_adr_o),
        .dat_out (pl_dat_o)
    );

    c2p_reply #(
        .DATA_W (DATA_W)
    ) u_reply (
        .state   (state),
        .dropped (dropped),
        .cm_cyc  (cm_cyc_i),
        .cm_stb  (cm_stb_i),
        .pl_ack  (pl_ack_i),
        .pl_dat  (pl_dat_i),
        .cm_ack  (cm_ack_o),
        .cm_dat  (cm_dat_o)
    );

    assign pl_cyc_o = (state != ST_IDLE);
    assign pl_stb_o = (state == ST_REQ);

endmodule

// File: rtl/wbc2p_bridge_chk.sv
module wbc2p_bridge_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cm_ack_o,
    input logic              pl_cyc_o,
    input logic              pl_stb_o,
    input logic              pl_we_o,
    input logic [ADDR_W-1:0] pl_adr_o,
    input logic [DATA_W-1:0] pl_dat_o,
    input logic              pl_stall_i,
    input logic              pl_ack_i
);

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pl_stb_o && pl_stall_i) |=> (pl_stb_o && $stable(pl_adr_o)
                                      && $stable(pl_we_o) && $stable(pl_dat_o)));

    // R4
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (pl_stb_o && !pl_stall_i) |=> !pl_stb_o);

    // R5
    stb_in_cyc_chk: assert property (@(posedge clk) disable iff (rst)
        pl_stb_o |-> pl_cyc_o);

    // R5
    cyc_close_chk: assert property (@(posedge clk) disable iff (rst)
        (pl_cyc_o && !pl_stb_o && pl_ack_i) |=> !pl_cyc_o);

    // R8
    cyc_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (pl_cyc_o && !pl_stb_o && !pl_ack_i) |=> pl_cyc_o);

    // R6
    ack_source_chk: assert property (@(posedge clk) disable iff (rst)
        cm_ack_o |-> pl_ack_i);

    // R6
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cm_ack_o |=> !cm_ack_o);

    // R9
    idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
        !pl_cyc_o |-> !cm_ack_o);

endmodule

bind wbc2p_bridge wbc2p_bridge_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .cm_ack_o   (cm_ack_o),
    .pl_cyc_o   (pl_cyc_o),
    .pl_stb_o   (pl_stb_o),
    .pl_we_o    (pl_we_o),
    .pl_adr_o   (pl_adr_o),
    .pl_dat_o   (pl_dat_o),
    .pl_stall_i (pl_stall_i),
    .pl_ack_i   (pl_ack_i)
);

// File: tb/test_wbc2p_bridge.sv
module test_wbc2p_bridge;

    localparam int  ADDR_W  = 32;
    localparam int  DATA_W  = 32;
    localparam time CLK_PER = 10ns;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cm_cyc_i = 1'b0;
    logic              cm_stb_i = 1'b0;
    logic              cm_we_i = 1'b0;
    logic [ADDR_W-1:0] cm_adr_i = '0;
    logic [DATA_W-1:0] cm_dat_i = '0;
    logic [DATA_W-1:0] cm_dat_o;
    logic              cm_ack_o;
    logic              pl_cyc_o;
    logic              pl_stb_o;
    logic              pl_we_o;
    logic [ADDR_W-1:0] pl_adr_o;
    logic [DATA_W-1:0] pl_dat_o;
    logic [DATA_W-1:0] pl_dat_i = '0;
    logic              pl_stall_i = 1'b0;
    logic              pl_ack_i = 1'b0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PER/2) clk = ~clk;

    wbc2p_bridge #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_wbc2p_bridge (
        .clk        (clk),
        .rst        (rst),
        .cm_cyc_i   (cm_cyc_i),
        .cm_stb_i   (cm_stb_i),
        .cm_we_i    (cm_we_i),
        .cm_adr_i   (cm_adr_i),
        .cm_dat_i   (cm_dat_i),
        .cm_dat_o   (cm_dat_o),
        .cm_ack_o   (cm_ack_o),
        .pl_cyc_o   (pl_cyc_o),
        .pl_stb_o   (pl_stb_o),
        .pl_we_o    (pl_we_o),
        .pl_adr_o   (pl_adr_o),
        .pl_dat_o   (pl_dat_o),
        .pl_dat_i   (pl_dat_i),
        .pl_stall_i (pl_stall_i),
        .pl_ack_i   (pl_ack_i)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One classic transfer against a slave that stalls stall_n cycles
    // and acknowledges lat cycles after acceptance.
    task automatic xfer(input logic we, input logic [ADDR_W-1:0] adr,
                        input logic [DATA_W-1:0] wdat, input logic [DATA_W-1:0] rdat,
                        input int stall_n, input int lat);
        int stb_cycles;
        @(negedge clk);
        cm_cyc_i = 1'b1; cm_stb_i = 1'b1;
        cm_we_i = we; cm_adr_i = adr; cm_dat_i = wdat;
        pl_stall_i = (stall_n > 0);
        @(negedge clk);
        chk("R2 cyc", pl_cyc_o, 1);
        chk("R2 stb", pl_stb_o, 1);
        chk("R2 adr", pl_adr_o, adr);
        chk("R2 we", pl_we_o, we);
        if (we) chk("R2 wdat", pl_dat_o, wdat);
        stb_cycles = 1;
        for (int i = 1; i <= stall_n; i++) begin
            @(negedge clk);
            chk("R3 stb held", pl_stb_o, 1);
            chk("R3 adr held", pl_adr_o, adr);
            if (pl_stb_o) stb_cycles++;
            if (i == stall_n) pl_stall_i = 1'b0;
        end
        @(negedge clk);
        chk("R4 stb dropped", pl_stb_o, 0);
        chk("R4 strobe count", stb_cycles, stall_n + 1);
        chk("R5 cyc open", pl_cyc_o, 1);
        for (int j = 1; j < lat; j++) begin
            #1 chk("R7 no early ack", cm_ack_o, 0);
            @(negedge clk);
            chk("R5 cyc waits", pl_cyc_o, 1);
        end
        pl_ack_i = 1'b1; pl_dat_i = rdat;
        #1;
        chk("R6 ack", cm_ack_o, 1);
        if (!we) chk("R6 rdata", cm_dat_o, rdat);
        @(negedge clk);
        pl_ack_i = 1'b0;
        cm_cyc_i = 1'b0; cm_stb_i = 1'b0;
        #1;
        chk("R5 cyc closed", pl_cyc_o, 0);
        chk("R6 ack one cycle", cm_ack_o, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 cyc", pl_cyc_o, 0);
        chk("R1 stb", pl_stb_o, 0);
        chk("R1 ack", cm_ack_o, 0);
        rst = 1'b0;
    endtask

    task automatic t_write_fast();
        xfer(1'b1, 32'h0000_0040, 32'hCAFE_0001, 32'h0, 0, 1);
    endtask

    task automatic t_read_stalled();
        xfer(1'b0, 32'h0000_1234, 32'h0, 32'hDEAD_BEEF, 3, 2);
    endtask

    task automatic t_write_slow();
        xfer(1'b1, 32'hFFFF_FFFC, 32'h5A5A_A5A5, 32'h0, 1, 4);
    endtask

    task automatic t_read_late();
        xfer(1'b0, 32'h0000_0008, 32'h0, 32'h0123_4567, 0, 5);
    endtask

    task automatic t_back_to_back();
        xfer(1'b0, 32'h0000_0100, 32'h0, 32'h1111_2222, 2, 1);
        xfer(1'b1, 32'h0000_0104, 32'h3333_4444, 32'h0, 0, 3);
    endtask

    task automatic t_abort();
        @(negedge clk);
        cm_cyc_i = 1'b1; cm_stb_i = 1'b1;
        cm_we_i = 1'b0; cm_adr_i = 32'h0000_0200;
        pl_stall_i = 1'b0;
        @(negedge clk);
        chk("R8 strobe", pl_stb_o, 1);
        @(negedge clk);
        cm_cyc_i = 1'b0; cm_stb_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R8 cyc kept", pl_cyc_o, 1);
        end
        pl_ack_i = 1'b1; pl_dat_i = 32'hBAD0_BAD0;
        #1 chk("R8 ack swallowed", cm_ack_o, 0);
        @(negedge clk);
        pl_ack_i = 1'b0;
        #1 chk("R8 cyc closed", pl_cyc_o, 0);
    endtask

    task automatic t_stray_ack();
        @(negedge clk);
        pl_ack_i = 1'b1;
        #1 chk("R9 no ack", cm_ack_o, 0);
        @(negedge clk);
        pl_ack_i = 1'b0;
        #1 chk("R9 cyc idle", pl_cyc_o, 0);
        chk("R9 stb idle", pl_stb_o, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1..R9 actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_stray_ack();
        t_write_fast();
        t_read_stalled();
        t_write_slow();
        t_read_late();
        t_back_to_back();
        t_abort();
        t_stray_ack();
        t_write_fast();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule